// File: doc/BRIEF.md
# Per-Device Selective Refresh Scheduler

This block lives inside a DRAM memory controller and decides, for every refresh command, which devices of a sixteen-device rank take part. Each device has its own chip select. The five devices that hold the sign and exponent bits of stored floating-point words are refreshed every retention round. The eleven devices that hold mantissa bits are refreshed only once every few rounds, so most of their refresh energy is saved at the cost of rare low-order bit errors.

An interval timer raises a refresh request once per refresh interval. A row counter walks through every row once per retention round, and each completed walk ends one round. For each approximate device a per-device phase counter tracks the round number modulo that device's period. The period is `cfg_offset + cfg_incr * (10 - n)` rounds for device n, so less significant devices wait longer. While a request is pending the block presents the row and a chip-select mask. Downstream command logic issues the refresh and then acknowledges it.

Top module: `selref_sched`

## Requirements
- R1: While `rst_n` is low and right after it rises, `ref_req` is 0, `ref_row` is 0 and `ref_cs_mask` is all zero; the round count starts at 0.
- R2: The interval timer counts `CYC_PER_INTERVAL` clock cycles per interval. The first refresh is owed after the `CYC_PER_INTERVAL`-th rising edge following reset release, and one more is owed every `CYC_PER_INTERVAL` cycles after that.
- R3: `ref_req` stays high and `ref_row` stays unchanged until a cycle in which `ref_ack` is 1 while `ref_req` is 1. An `ref_ack` given while `ref_req` is 0 changes nothing.
- R4: Owed refreshes are counted up to `MAX_OWED` and saturate there. `ref_req` stays high until every owed refresh has been acknowledged. A new interval and an acknowledge in the same cycle leave the count unchanged.
- R5: Each acknowledged request advances `ref_row` by one. After row `ROWS-1` it wraps to 0, and that wrap ends the current round.
- R6: While `ref_req` is 1, mask bits 15 down to 11 (the precise devices) are all 1.
- R7: While `ref_req` is 1 in round r, mask bit n for n in 0..10 is 1 exactly when r modulo P_n is 0. P_n = `cfg_offset + cfg_incr*(10-n)`, with both inputs in units of one 64 ms round. In round 0 every bit is 1.
- R8: A computed P_n of 0 is used as 1, so the device is refreshed every round. A P_n above `MAX_PERIOD` (default 64 rounds, 4096 ms) is used as `MAX_PERIOD`.
- R9: While `ref_req` is 0, `ref_cs_mask` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offset | input | CFG_W | Base period of approximate devices, in 64 ms rounds |
| cfg_incr | input | CFG_W | Extra rounds per step of lower significance |
| ref_ack | input | 1 | Refresh issued for the presented row and mask |
| ref_req | output | 1 | At least one refresh is owed |
| ref_row | output | $clog2(ROWS) | Row to refresh |
| ref_cs_mask | output | NUM_DEV | Chip select per device, 1 = take part |

## Verification
On every cycle the assertions check four things: the request and row hold while no acknowledge arrives, the row steps and wraps on each acknowledge, the precise devices are always selected during a request, and the mask is empty while idle. Which approximate devices are selected in which round depends on the round history and on the period arithmetic. Interval timing and saturation of owed refreshes also depend on long stretches of history. Only the bench's reference model, run against several offset and increment settings and acknowledge patterns, can show those.

// File: rtl/selref_pkg.sv
package selref_pkg;

    // Refresh period in rounds for an approximate device of the given rank
    // (rank 0 = most significant approximate device), bounded to [1, maxp].
    function automatic int unsigned dev_period(input int unsigned off,
                                               input int unsigned inc,
                                               input int unsigned rank,
                                               input int unsigned maxp);
        int unsigned p;
        p = off + inc * rank;
        if (p == 0) p = 1;
        if (p > maxp) p = maxp;
        return p;
    endfunction

endpackage

// File: rtl/selref_interval.sv
module selref_interval #(
    parameter int CYC_PER_INTERVAL = 6240,
    parameter int MAX_OWED         = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served,
    output logic pending
);
    localparam int CW = (CYC_PER_INTERVAL > 1) ? $clog2(CYC_PER_INTERVAL) : 1;
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [CW-1:0] T_LAST = CW'(CYC_PER_INTERVAL - 1);
    localparam logic [OW-1:0] O_MAX  = OW'(MAX_OWED);

    typedef struct packed {
        logic [CW-1:0] tcnt;
        logic [OW-1:0] owed;
    } tmr_t;

    tmr_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.tcnt == T_LAST);
        st_d.tcnt = tick ? '0 : st_q.tcnt + 1'b1;
        if (tick && !served) begin
            if (st_q.owed != O_MAX) st_d.owed = st_q.owed + 1'b1;
        end else if (!tick && served && st_q.owed != '0) begin
            st_d.owed = st_q.owed - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = (st_q.owed != '0);
endmodule

// File: rtl/selref_rowctr.sv
module selref_rowctr #(
    parameter int ROWS = 8192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    output logic [$clog2(ROWS)-1:0] row,
    output logic                    round_end
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
    } rc_t;

    rc_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        round_end = step && (st_q.row == R_LAST);
        if (step) st_d.row = round_end ? '0 : st_q.row + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row = st_q.row;
endmodule

// File: rtl/selref_phase.sv
module selref_phase
    import selref_pkg::*;
#(
    parameter int NUM_DEV     = 16,
    parameter int NUM_PRECISE = 5,
    parameter int MAX_PERIOD  = 64,
    parameter int CFG_W       = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_offset,
    input  logic [CFG_W-1:0]   cfg_incr,
    input  logic               round_end,
    output logic [NUM_DEV-1:0] sel
);
    localparam int NUM_APPROX = NUM_DEV - NUM_PRECISE;
    localparam int PW = (MAX_PERIOD > 1) ? $clog2(MAX_PERIOD) : 1;

    for (genvar n = 0; n < NUM_DEV; n++) begin : g_dev
        if (n >= NUM_APPROX) begin : g_precise
            assign sel[n] = 1'b1;
        end else begin : g_approx
            logic [PW-1:0] phase_d, phase_q;
            int unsigned   period;
            int unsigned   nxt;

            always_comb begin
                period  = dev_period(int'(cfg_offset), int'(cfg_incr),
                                     NUM_APPROX - 1 - n, MAX_PERIOD);
                nxt     = int'(phase_q) + 1;
                phase_d = phase_q;
                if (round_end) phase_d = (nxt >= period) ? '0 : PW'(nxt);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) phase_q <= '0;
                else        phase_q <= phase_d;
            end

            assign sel[n] = (phase_q == '0);
        end
    end
endmodule

// File: rtl/selref_sched.sv
module selref_sched #(
    parameter int CYC_PER_INTERVAL = 6240,
    parameter int ROWS             = 8192,
    parameter int MAX_OWED         = 8,
    parameter int NUM_DEV          = 16,
    parameter int NUM_PRECISE      = 5,
    parameter int MAX_PERIOD       = 64,
    parameter int CFG_W            = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CFG_W-1:0]        cfg_offset,
    input  logic [CFG_W-1:0]        cfg_incr,
    input  logic                    ref_ack,
    output logic                    ref_req,
    output logic [$clog2(ROWS)-1:0] ref_row,
    output logic [NUM_DEV-1:0]      ref_cs_mask
);
    logic               served;
    logic               round_end;
    logic [NUM_DEV-1:0] dev_sel;

    assign served = ref_req && ref_ack;

    selref_interval #(
        .CYC_PER_INTERVAL(CYC_PER_INTERVAL),
        .MAX_OWED        (MAX_OWED)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .served (served),
        .pending(ref_req)
    );

    selref_rowctr #(.ROWS(ROWS)) u_rowctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (served),
        .row      (ref_row),
        .round_end(round_end)
    );

    selref_phase #(
        .NUM_DEV    (NUM_DEV),
        .NUM_PRECISE(NUM_PRECISE),
        .MAX_PERIOD (MAX_PERIOD),
        .CFG_W      (CFG_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_offset(cfg_offset),
        .cfg_incr  (cfg_incr),
        .round_end (round_end),
        .sel       (dev_sel)
    );

    assign ref_cs_mask = ref_req ? dev_sel : '0;
endmodule

// File: rtl/selref_sched_chk.sv
module selref_sched_chk #(
    parameter int ROWS        = 8192,
    parameter int NUM_DEV     = 16,
    parameter int NUM_PRECISE = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ref_ack,
    input logic                    ref_req,
    input logic [$clog2(ROWS)-1:0] ref_row,
    input logic [NUM_DEV-1:0]      ref_cs_mask
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);
    localparam logic [NUM_DEV-1:0] PREC_MASK =
        {{NUM_PRECISE{1'b1}}, {(NUM_DEV-NUM_PRECISE){1'b0}}};

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_row)));

    assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack && ref_row != R_LAST) |=> (ref_row == RW'($past(ref_row) + 1'b1)));

    assert_row_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack && ref_row == R_LAST) |=> (ref_row == '0));

    assert_precise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ((ref_cs_mask & PREC_MASK) == PREC_MASK));

    assert_idle_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ref_cs_mask == '0));

    assert_noreq_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && ref_ack) |=> $stable(ref_row));
endmodule

bind selref_sched selref_sched_chk #(
    .ROWS       (ROWS),
    .NUM_DEV    (NUM_DEV),
    .NUM_PRECISE(NUM_PRECISE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ack    (ref_ack),
    .ref_req    (ref_req),
    .ref_row    (ref_row),
    .ref_cs_mask(ref_cs_mask)
);

// File: tb/selref_sched_bench.sv
`timescale 1ns/1ps
module selref_sched_bench;
    localparam int CYC   = 20;
    localparam int ROWS  = 4;
    localparam int MAXO  = 8;
    localparam int NDEV  = 16;
    localparam int NPREC = 5;
    localparam int MAXP  = 64;
    localparam int CW    = 7;
    localparam int RW    = $clog2(ROWS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg_offset = '0;
    logic [CW-1:0]   cfg_incr = '0;
    logic            ref_ack = 1'b0;
    logic            ref_req;
    logic [RW-1:0]   ref_row;
    logic [NDEV-1:0] ref_cs_mask;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int m_tcnt = 0, m_owed = 0, m_row = 0, m_rnd = 0;
    int max_owed_seen = 0;

    always #5 clk = ~clk;

    selref_sched #(
        .CYC_PER_INTERVAL(CYC), .ROWS(ROWS), .MAX_OWED(MAXO),
        .NUM_DEV(NDEV), .NUM_PRECISE(NPREC), .MAX_PERIOD(MAXP), .CFG_W(CW)
    ) u_selref_sched (
        .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_incr(cfg_incr),
        .ref_ack(ref_ack), .ref_req(ref_req), .ref_row(ref_row),
        .ref_cs_mask(ref_cs_mask)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tcnt = 0; m_owed = 0; m_row = 0; m_rnd = 0;
        end else begin
            bit tick, hs;
            tick = (m_tcnt == CYC - 1);
            hs   = (m_owed != 0) && ref_ack;
            m_tcnt = tick ? 0 : m_tcnt + 1;
            if (hs) begin
                if (m_row == ROWS - 1) begin m_row = 0; m_rnd++; end
                else m_row++;
            end
            m_owed = m_owed + int'(tick) - int'(hs);
            if (m_owed > MAXO) m_owed = MAXO;
            if (m_owed > max_owed_seen) max_owed_seen = m_owed;
        end
    end

    function automatic logic [NDEV-1:0] exp_mask();
        logic [NDEV-1:0] m;
        m = '0;
        if (m_owed != 0) begin
            for (int n = 0; n < NDEV; n++) begin
                if (n >= NDEV - NPREC) m[n] = 1'b1;
                else begin
                    int p;
                    p = int'(cfg_offset) + int'(cfg_incr) * (NDEV - NPREC - 1 - n);
                    if (p == 0) p = 1;
                    if (p > MAXP) p = MAXP;
                    m[n] = ((m_rnd % p) == 0);
                end
            end
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic compare();
        logic [NDEV-1:0] em;
        em = exp_mask();
        if (!rst_n) begin
            check(ref_req == 1'b0 && ref_row == '0 && ref_cs_mask == '0, "R1 reset",
                  int'({ref_req, ref_cs_mask}), 0);
            return;
        end
        check(ref_req == (m_owed != 0), "R2/R3/R4 req", int'(ref_req), int'(m_owed != 0));
        check(int'(ref_row) == m_row, "R5 row", int'(ref_row), m_row);
        if (m_owed != 0) begin
            check(ref_cs_mask[NDEV-1:NDEV-NPREC] == em[NDEV-1:NDEV-NPREC], "R6 precise",
                  int'(ref_cs_mask), int'(em));
            check(ref_cs_mask[NDEV-NPREC-1:0] == em[NDEV-NPREC-1:0], "R7/R8 approx",
                  int'(ref_cs_mask), int'(em));
        end else begin
            check(ref_cs_mask == '0, "R9 idle mask", int'(ref_cs_mask), 0);
        end
    endtask

    // mode: 0 ack always, 1 pseudo-random, 2 ack low
    task automatic run(input int cycles, input int mode);
        logic [7:0] lfsr = 8'hA5;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare();
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (mode)
                0: ref_ack = 1'b1;
                1: ref_ack = lfsr[0] & lfsr[3];
                default: ref_ack = 1'b0;
            endcase
        end
    endtask

    task automatic do_reset(input int off, input int inc);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_offset = CW'(off);
        cfg_incr = CW'(inc);
        ref_ack = 1'b0;
        run(3, 2);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic scenarios();
        // R1/R2: first request after CYC edges; ack before any request (R3)
        do_reset(0, 0);
        ref_ack = 1'b1;
        run(CYC - 1, 0);
        check(ref_req == 1'b0, "R2 early req", int'(ref_req), 0);
        run(2000, 0);                          // R8: zero period -> every round
        do_reset(16, 4);                       // R7: periods 56..16 rounds
        run(9000, 1);
        check(m_rnd >= 56, "R7 rounds reached", m_rnd, 56);
        do_reset(60, 10);                      // R8: clamp to 64 rounds
        run(6000, 0);
        check(m_rnd >= 64, "R8 rounds reached", m_rnd, 64);
        do_reset(2, 1);                        // R4: saturation of owed count
        run(CYC * (MAXO + 4), 2);
        check(max_owed_seen == MAXO, "R4 saturation", max_owed_seen, MAXO);
        run(600, 0);
        run(600, 1);
    endtask

    initial begin
        fork
            scenarios();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule